// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with Fixed Accumulator Placement

The unit performs integer multiplication and division one operand bit per clock, the way the arithmetic unit of a small 16-bit processor does. The caller supplies an operation code, a size flag (byte or word), the current accumulator and extension register values, and a source operand. It pulses `start_i`. Some cycles later the unit pulses `done_o` and presents the new accumulator and extension values, which the caller writes back to its register file. It also presents a carry/overflow pair for multiplies and an error flag for divides.

Where each result lands is fixed by the operand size. Byte multiplies fill the whole accumulator. Word multiplies spread across extension:accumulator. Byte divides split the accumulator into a quotient byte and a remainder byte. Word divides put the quotient in the accumulator and the remainder in the extension register. Signed and unsigned forms share a single shift-add / restoring-subtract datapath. Magnitudes are taken before the iterations, and the sign is applied after them.

Top module: `muldiv_unit`

## Requirements
- R1: Byte multiply (`word_i`=0) multiplies the low accumulator byte by `src_i[7:0]` and places the 16-bit product in `acc_o`, with `ext_o` equal to `ext_i`. `op_i` 2'b00 is unsigned multiply and 2'b01 is two's-complement multiply.
- R2: Word multiply (`word_i`=1) multiplies `acc_i` by `src_i`. The upper 16 product bits go to `ext_o` and the lower 16 to `acc_o`.
- R3: After a multiply, `cf_o` and `of_o` are both 1 exactly when the upper half of the product is significant. For unsigned this means the upper half is nonzero. For signed it means the upper half is not the sign extension of the lower half. Both flags are 0 after any divide.
- R4: Byte divide (`op_i` 2'b10 unsigned, 2'b11 signed, `word_i`=0) divides the 16-bit `acc_i` by `src_i[7:0]`. `acc_o[7:0]` is the quotient, `acc_o[15:8]` is the remainder, and `ext_o` equals `ext_i`.
- R5: Word divide divides the 32-bit value {`ext_i`,`acc_i`} by `src_i`. `acc_o` is the quotient and `ext_o` is the remainder.
- R6: Signed divide truncates the quotient toward zero. The remainder carries the sign of the dividend.
- R7: A zero divisor, or a quotient outside the destination range (unsigned 0..2^N-1; signed -2^(N-1)..2^(N-1)-1, where N is 8 or 16), sets `div_err_o`. In that case `acc_o`/`ext_o` equal the `acc_i`/`ext_i` sampled at start, and the flags are 0.
- R8: `done_o` is a one-cycle pulse. It appears N+1 clock edges after the edge that accepts `start_i` (N=8 for byte, 16 for word). `busy_o` is high from the accepting edge until the cycle of `done_o`. Outputs change only together with `done_o`.
- R9: `start_i` is ignored while `busy_o` is high. The running operation completes with its own result, and no extra `done_o` follows.
- R10: After reset, `acc_o`, `ext_o`, `done_o`, `busy_o`, `div_err_o`, `cf_o` and `of_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (accepted when not busy) |
| op_i | input | 2 | 00 mul unsigned, 01 mul signed, 10 div unsigned, 11 div signed |
| word_i | input | 1 | 1 = word operands, 0 = byte operands |
| acc_i | input | 16 | Current accumulator value |
| ext_i | input | 16 | Current extension register value |
| src_i | input | 16 | Source operand (low byte used for byte size) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| acc_o | output | 16 | New accumulator value |
| ext_o | output | 16 | New extension register value |
| div_err_o | output | 1 | Divide error (zero divisor or quotient overflow) |
| cf_o | output | 1 | Carry: multiply upper half significant |
| of_o | output | 1 | Overflow: multiply upper half significant |

## Verification
A wrong iteration count or a stuck control state shows up first as a shifted or missing `done_o`. That is visible within one operation: 10 cycles for a byte operation, 18 for a word operation. A flaw in the datapath, such as a lost carry in the partial product, a restoring step that does not restore, or a sign applied to the wrong term, stays hidden until the result strobe. It then shows up as a wrong accumulator or extension value, or as a wrongly set flag. For this reason the vectors pair every operation with both sizes and both signs, plus the edge quotients -128 and 128 and the full-scale product 0xFFFF*0xFFFF. A missed overflow check shows as modified register outputs where the saved inputs were expected.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_DIVS = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIX
  } md_state_e;
endpackage

// File: rtl/muldiv_prep.sv
// Operand conditioning: sign extension, magnitudes, early divide check.
module muldiv_prep #(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        op_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] ext_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] mcand_o,
  output logic [DATA_W-1:0] mplier_o,
  output logic [DATA_W-1:0] rem_o,
  output logic              neg_q_o,
  output logic              neg_r_o,
  output logic              pre_err_o
);
  localparam int H = DATA_W / 2;

  logic              is_div, is_sgn;
  logic [DATA_W-1:0] a_x, s_x, a_mag, s_mag, hi, lo;
  logic [2*DATA_W-1:0] d_x, d_mag;
  logic              a_neg, s_neg, d_neg;

  assign is_div = op_i[1];
  assign is_sgn = op_i[0];

  always_comb begin
    a_x   = word_i ? acc_i : {{H{is_sgn & acc_i[H-1]}}, acc_i[H-1:0]};
    s_x   = word_i ? src_i : {{H{is_sgn & src_i[H-1]}}, src_i[H-1:0]};
    d_x   = word_i ? {ext_i, acc_i} : {{DATA_W{is_sgn & acc_i[DATA_W-1]}}, acc_i};
    a_neg = is_sgn & a_x[DATA_W-1];
    s_neg = is_sgn & s_x[DATA_W-1];
    d_neg = is_sgn & d_x[2*DATA_W-1];
    a_mag = a_neg ? -a_x : a_x;
    s_mag = s_neg ? -s_x : s_x;
    d_mag = d_neg ? -d_x : d_x;
    // byte dividend is left-aligned so the bit feed is always taken from the MSB
    hi    = word_i ? d_mag[2*DATA_W-1:DATA_W] : {{H{1'b0}}, d_mag[DATA_W-1:H]};
    lo    = word_i ? d_mag[DATA_W-1:0] : {d_mag[H-1:0], {H{1'b0}}};
  end

  assign mcand_o   = is_div ? s_mag : a_mag;
  assign mplier_o  = is_div ? lo : s_mag;
  assign rem_o     = hi;
  assign neg_q_o   = is_div ? (d_neg ^ s_neg) : (a_neg ^ s_neg);
  assign neg_r_o   = d_neg;
  assign pre_err_o = is_div & ((s_mag == '0) | (hi >= s_mag));
endmodule

// File: rtl/muldiv_iter.sv
// One bit per step: shift-add multiply or restoring divide on shared registers.
module muldiv_iter #(
  parameter int DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                step_i,
  input  logic                is_div_i,
  input  logic [DATA_W-1:0]   mcand_i,
  input  logic [DATA_W-1:0]   mplier_i,
  input  logic [DATA_W-1:0]   rem_i,
  output logic [2*DATA_W-1:0] prod_o,
  output logic [DATA_W-1:0]   rem_o,
  output logic [DATA_W-1:0]   quo_o
);
  logic [2*DATA_W-1:0] mc_q, sum_q;
  logic [DATA_W-1:0]   mp_q, rem_q, quo_q;
  logic [DATA_W:0]     shifted, diff;
  logic                ge;

  always_comb begin
    shifted = {rem_q, mp_q[DATA_W-1]};
    diff    = shifted - {1'b0, mc_q[DATA_W-1:0]};
    ge      = shifted >= {1'b0, mc_q[DATA_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc_q  <= '0;
      mp_q  <= '0;
      sum_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
    end else if (load_i) begin
      mc_q  <= {{DATA_W{1'b0}}, mcand_i};
      mp_q  <= mplier_i;
      sum_q <= '0;
      rem_q <= rem_i;
      quo_q <= '0;
    end else if (step_i) begin
      if (is_div_i) begin
        rem_q <= ge ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
        quo_q <= {quo_q[DATA_W-2:0], ge};
        mp_q  <= mp_q << 1;
      end else begin
        if (mp_q[0]) sum_q <= sum_q + mc_q;
        mc_q <= mc_q << 1;
        mp_q <= mp_q >> 1;
      end
    end
  end

  assign prod_o = sum_q;
  assign rem_o  = rem_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/muldiv_fix.sv
// Sign restore, overflow/significance checks and result placement.
module muldiv_fix #(
  parameter int DATA_W = 16
) (
  input  logic                is_div_i,
  input  logic                is_sgn_i,
  input  logic                word_i,
  input  logic                neg_q_i,
  input  logic                neg_r_i,
  input  logic                pre_err_i,
  input  logic [2*DATA_W-1:0] prod_i,
  input  logic [DATA_W-1:0]   rem_i,
  input  logic [DATA_W-1:0]   quo_i,
  input  logic [DATA_W-1:0]   acc_keep_i,
  input  logic [DATA_W-1:0]   ext_keep_i,
  output logic [DATA_W-1:0]   acc_o,
  output logic [DATA_W-1:0]   ext_o,
  output logic                err_o,
  output logic                sig_o
);
  localparam int H = DATA_W / 2;

  logic [2*DATA_W-1:0] p;
  logic [DATA_W-1:0]   q, r, lim;
  logic                sovf, hi_sig;

  always_comb begin
    p   = neg_q_i ? -prod_i : prod_i;
    q   = neg_q_i ? -quo_i : quo_i;
    r   = neg_r_i ? -rem_i : rem_i;
    lim = word_i ? {1'b1, {(DATA_W-1){1'b0}}} : {{H{1'b0}}, 1'b1, {(H-1){1'b0}}};
    sovf = is_sgn_i & (neg_q_i ? (quo_i > lim) : (quo_i >= lim));
    if (word_i)
      hi_sig = is_sgn_i ? (p[2*DATA_W-1:DATA_W] != {DATA_W{p[DATA_W-1]}})
                        : (p[2*DATA_W-1:DATA_W] != '0);
    else
      hi_sig = is_sgn_i ? (p[DATA_W-1:H] != {H{p[H-1]}}) : (p[DATA_W-1:H] != '0);

    acc_o = acc_keep_i;
    ext_o = ext_keep_i;
    err_o = 1'b0;
    sig_o = 1'b0;
    if (!is_div_i) begin
      acc_o = p[DATA_W-1:0];
      if (word_i) ext_o = p[2*DATA_W-1:DATA_W];
      sig_o = hi_sig;
    end else if (pre_err_i || sovf) begin
      err_o = 1'b1;
    end else if (word_i) begin
      acc_o = q;
      ext_o = r;
    end else begin
      acc_o = {r[H-1:0], q[H-1:0]};
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] ext_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] ext_o,
  output logic              div_err_o,
  output logic              cf_o,
  output logic              of_o
);
  import muldiv_pkg::*;

  localparam int H  = DATA_W / 2;
  localparam int CW = $clog2(DATA_W + 1);

  md_state_e         state_q;
  md_op_e            op_q;
  logic [CW-1:0]     cnt_q;
  logic              word_q, neg_q_q, neg_r_q, pre_err_q;
  logic [DATA_W-1:0] acc_keep_q, ext_keep_q;
  logic [DATA_W-1:0] acc_q, ext_q;
  logic              done_q, err_q, sig_q;

  logic              accept;
  logic [DATA_W-1:0] mcand, mplier, rem_init, it_rem, it_quo, acc_n, ext_n;
  logic [2*DATA_W-1:0] it_prod;
  logic              neg_q, neg_r, pre_err, err_n, sig_n;

  assign accept = start_i && (state_q == ST_IDLE);

  muldiv_prep #(.DATA_W(DATA_W)) u_prep (
    .op_i     (op_i),
    .word_i   (word_i),
    .acc_i    (acc_i),
    .ext_i    (ext_i),
    .src_i    (src_i),
    .mcand_o  (mcand),
    .mplier_o (mplier),
    .rem_o    (rem_init),
    .neg_q_o  (neg_q),
    .neg_r_o  (neg_r),
    .pre_err_o(pre_err)
  );

  muldiv_iter #(.DATA_W(DATA_W)) u_iter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .step_i  (state_q == ST_RUN),
    .is_div_i(op_q[1]),
    .mcand_i (mcand),
    .mplier_i(mplier),
    .rem_i   (rem_init),
    .prod_o  (it_prod),
    .rem_o   (it_rem),
    .quo_o   (it_quo)
  );

  muldiv_fix #(.DATA_W(DATA_W)) u_fix (
    .is_div_i  (op_q[1]),
    .is_sgn_i  (op_q[0]),
    .word_i    (word_q),
    .neg_q_i   (neg_q_q),
    .neg_r_i   (neg_r_q),
    .pre_err_i (pre_err_q),
    .prod_i    (it_prod),
    .rem_i     (it_rem),
    .quo_i     (it_quo),
    .acc_keep_i(acc_keep_q),
    .ext_keep_i(ext_keep_q),
    .acc_o     (acc_n),
    .ext_o     (ext_n),
    .err_o     (err_n),
    .sig_o     (sig_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_MULU;
      cnt_q      <= '0;
      word_q     <= 1'b0;
      neg_q_q    <= 1'b0;
      neg_r_q    <= 1'b0;
      pre_err_q  <= 1'b0;
      acc_keep_q <= '0;
      ext_keep_q <= '0;
      acc_q      <= '0;
      ext_q      <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      sig_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q    <= ST_RUN;
          op_q       <= md_op_e'(op_i);
          word_q     <= word_i;
          cnt_q      <= word_i ? CW'(DATA_W) : CW'(H);
          neg_q_q    <= neg_q;
          neg_r_q    <= neg_r;
          pre_err_q  <= pre_err;
          acc_keep_q <= acc_i;
          ext_keep_q <= ext_i;
        end
        ST_RUN: begin
          cnt_q <= cnt_q - CW'(1);
          if (cnt_q == CW'(1)) state_q <= ST_FIX;
        end
        ST_FIX: begin
          state_q <= ST_IDLE;
          acc_q   <= acc_n;
          ext_q   <= ext_n;
          err_q   <= err_n;
          sig_q   <= sig_n;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign acc_o     = acc_q;
  assign ext_o     = ext_q;
  assign div_err_o = err_q;
  assign cf_o      = sig_q;
  assign of_o      = sig_q;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              word_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] ext_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [DATA_W-1:0] ext_o,
  input logic              div_err_o,
  input logic              cf_o,
  input logic              of_o
);
  localparam int CW = $clog2(DATA_W + 2) + 1;

  logic [DATA_W-1:0] acc_cap, ext_cap;
  logic              word_cap;
  logic [CW-1:0]     lat_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cap  <= '0;
      ext_cap  <= '0;
      word_cap <= 1'b0;
      lat_cnt  <= '0;
    end else if (start_i && !busy_o) begin
      acc_cap  <= acc_i;
      ext_cap  <= ext_i;
      word_cap <= word_i;
      lat_cnt  <= '0;
    end else if (busy_o) begin
      lat_cnt <= lat_cnt + CW'(1);
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_cnt == (word_cap ? CW'(DATA_W + 1) : CW'(DATA_W / 2 + 1))));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(acc_o) && $stable(ext_o)));

  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_err_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_err_o) |-> (acc_o == acc_cap && ext_o == ext_cap && !cf_o && !of_o));

  assert_byte_ext_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !word_cap) |-> (ext_o == ext_cap));
endmodule

bind muldiv_unit muldiv_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .word_i   (word_i),
  .acc_i    (acc_i),
  .ext_i    (ext_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .acc_o    (acc_o),
  .ext_o    (ext_o),
  .div_err_o(div_err_o),
  .cf_o     (cf_o),
  .of_o     (of_o)
);

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] acc;
    logic [15:0] ext;
    logic        err;
    logic        cf;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        word_i = 1'b0;
  logic [15:0] acc_i = '0, ext_i = '0, src_i = '0;
  logic        busy_o, done_o, div_err_o, cf_o, of_o;
  logic [15:0] acc_o, ext_o;

  int   checks = 0;
  int   fails = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .op_i(op_i), .word_i(word_i),
    .acc_i(acc_i), .ext_i(ext_i), .src_i(src_i), .busy_o(busy_o), .done_o(done_o),
    .acc_o(acc_o), .ext_o(ext_o), .div_err_o(div_err_o), .cf_o(cf_o), .of_o(of_o)
  );

  function automatic exp_t model(input logic [1:0] op, input logic w,
                                 input logic [15:0] a, input logic [15:0] e,
                                 input logic [15:0] s, input string req);
    exp_t   x;
    longint pa, pb, p, dvd, dvs, q, r;
    x.acc = a; x.ext = e; x.err = 1'b0; x.cf = 1'b0; x.req = req;
    if (!op[1]) begin
      if (op[0]) begin
        pa = w ? longint'($signed(a)) : longint'($signed(a[7:0]));
        pb = w ? longint'($signed(s)) : longint'($signed(s[7:0]));
      end else begin
        pa = w ? longint'(a) : longint'(a[7:0]);
        pb = w ? longint'(s) : longint'(s[7:0]);
      end
      p = pa * pb;
      x.acc = p[15:0];
      if (w) x.ext = p[31:16];
      if (op[0]) x.cf = w ? (p < -32768 || p > 32767) : (p < -128 || p > 127);
      else       x.cf = w ? (p > 65535) : (p > 255);
    end else begin
      if (op[0]) begin
        dvd = w ? longint'($signed({e, a})) : longint'($signed(a));
        dvs = w ? longint'($signed(s)) : longint'($signed(s[7:0]));
      end else begin
        dvd = w ? longint'({e, a}) : longint'(a);
        dvs = w ? longint'(s) : longint'(s[7:0]);
      end
      if (dvs == 0) x.err = 1'b1;
      else begin
        q = dvd / dvs;
        r = dvd % dvs;
        if (op[0]) x.err = w ? (q < -32768 || q > 32767) : (q < -128 || q > 127);
        else       x.err = w ? (q > 65535) : (q > 255);
        if (!x.err) begin
          if (w) begin x.acc = q[15:0]; x.ext = r[15:0]; end
          else   x.acc = {r[7:0], q[7:0]};
        end
      end
    end
    return x;
  endfunction

  // monitor: compare each result strobe against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected done acc=%h expected no result", acc_o);
      end else begin
        exp_t x;
        x = exp_q.pop_front();
        if (acc_o !== x.acc || ext_o !== x.ext || div_err_o !== x.err ||
            cf_o !== x.cf || of_o !== x.cf) begin
          fails++;
          $display("FAIL %s got acc=%h ext=%h err=%b cf=%b of=%b expected acc=%h ext=%h err=%b cf=%b",
                   x.req, acc_o, ext_o, div_err_o, cf_o, of_o, x.acc, x.ext, x.err, x.cf);
        end
      end
    end
  end

  task automatic run_op(input logic [1:0] op, input logic w, input logic [15:0] a,
                        input logic [15:0] e, input logic [15:0] s, input string req,
                        input bit poke_busy = 1'b0);
    int k;
    exp_q.push_back(model(op, w, a, e, s, req));
    @(negedge clk);
    op_i = op; word_i = w; acc_i = a; ext_i = e; src_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = 1;
    checks++;
    if (busy_o !== 1'b1) begin
      fails++;
      $display("FAIL R8 busy after accept got %b expected 1", busy_o);
    end
    while (!done_o && k < 100) begin
      if (poke_busy && k == 3) begin
        // R9: a conflicting request while busy must be dropped
        op_i = ~op; word_i = ~w; acc_i = ~a; ext_i = ~e; src_i = 16'h0001; start_i = 1'b1;
      end else start_i = 1'b0;
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    checks++;
    if (k != (w ? 18 : 10)) begin
      fails++;
      $display("FAIL R8 latency got %0d expected %0d", k, w ? 18 : 10);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    checks++;
    if (acc_o !== 16'h0 || ext_o !== 16'h0 || done_o !== 1'b0 || busy_o !== 1'b0 ||
        div_err_o !== 1'b0 || cf_o !== 1'b0 || of_o !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset got acc=%h ext=%h done=%b busy=%b expected all zero",
               acc_o, ext_o, done_o, busy_o);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 byte multiply
    run_op(2'b00, 1'b0, 16'h12F0, 16'hBEEF, 16'h0030, "R1 mulu byte big");
    run_op(2'b00, 1'b0, 16'hAA05, 16'h1234, 16'hFF07, "R1 mulu byte small");
    run_op(2'b01, 1'b0, 16'h00FE, 16'h5A5A, 16'h0005, "R1 muls byte neg");
    run_op(2'b01, 1'b0, 16'h0080, 16'h0001, 16'h0080, "R3 muls byte -128*-128");
    // R2 word multiply
    run_op(2'b00, 1'b1, 16'hFFFF, 16'h0000, 16'hFFFF, "R2 mulu word full");
    run_op(2'b00, 1'b1, 16'h0100, 16'h7777, 16'h0010, "R3 mulu word fits");
    run_op(2'b01, 1'b1, 16'hFFFF, 16'h0000, 16'h0003, "R2 muls word -1*3");
    run_op(2'b01, 1'b1, 16'h8000, 16'h0000, 16'h8000, "R3 muls word min*min");
    // R4 byte divide
    run_op(2'b10, 1'b0, 16'h0064, 16'hCAFE, 16'h0007, "R4 divu byte 100/7");
    run_op(2'b10, 1'b0, 16'h00FF, 16'h0000, 16'h0001, "R4 divu byte max q");
    // R5 word divide
    run_op(2'b10, 1'b1, 16'h0000, 16'h0001, 16'h0003, "R5 divu word 65536/3");
    run_op(2'b10, 1'b1, 16'h1234, 16'h0000, 16'h1234, "R5 divu word equal");
    // R6 signed divide
    run_op(2'b11, 1'b0, 16'hFF9C, 16'h0000, 16'h0007, "R6 divs byte -100/7");
    run_op(2'b11, 1'b1, 16'hFF9C, 16'hFFFF, 16'hFFF9, "R6 divs word -100/-7");
    run_op(2'b11, 1'b0, 16'hFF80, 16'h0000, 16'h0001, "R6 divs byte q=-128");
    run_op(2'b11, 1'b0, 16'h0080, 16'h0000, 16'h00FF, "R6 divs byte 128/-1");
    // R7 divide errors
    run_op(2'b10, 1'b1, 16'h4321, 16'h0011, 16'h0000, "R7 div by zero");
    run_op(2'b10, 1'b0, 16'h0100, 16'h2222, 16'h0001, "R7 divu byte q=256");
    run_op(2'b11, 1'b0, 16'hFF80, 16'h3333, 16'h00FF, "R7 divs byte -128/-1");
    run_op(2'b11, 1'b0, 16'h0080, 16'h4444, 16'h0001, "R7 divs byte 128/1");
    run_op(2'b11, 1'b1, 16'h0000, 16'h8000, 16'hFFFF, "R7 divs word min/-1");
    // R9 start while busy
    run_op(2'b00, 1'b0, 16'h0009, 16'h0101, 16'h0009, "R9 first op kept", 1'b1);
    repeat (25) @(negedge clk);
    checks++;
    if (busy_o !== 1'b0 || exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9 after ignored start got busy=%b pending=%0d expected 0 0",
               busy_o, exp_q.size());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule